// File: doc/BRIEF.md
# Decimating Sample Averager With Freeze

This block turns a stream of 9-bit converter samples into a slower stream of averaged current readings. A configuration byte selects how many samples make up one window, any count from 1 to 256. The block sums the samples of a window, divides the total by the window length with a multi-cycle restoring divider, and publishes the truncated mean as the current reading.

Each published reading raises a new-data flag. The host clears the flag by pulsing the read input when it fetches the data word. A freeze level lets a host take a consistent snapshot across many sensors. While freeze is high, the published reading and the flag are held, and any average that completes during that time is dropped.

Samples must arrive at least 20 clock cycles apart, so that the divider always finishes before the next window can close.

Top module: `sample_averager`

## Requirements
- R1: The window length is N = avg_cfg + 1. Code 0x00 averages a single sample and code 0xFF averages 256 samples. No reading is published before the N-th sample of a window.
- R2: The published reading is floor(sum of the window's samples / N), 9 bits wide, covering 0 to 511.
- R3: Exactly one reading is produced per window of N samples. It appears on cur_value 19 clock edges after the edge that captures the window's last sample.
- R4: new_flag goes to 1 on the edge that publishes a reading. A high rd_pulse clears it on the next edge. When a publish and rd_pulse land on the same edge, the flag stays 1.
- R5: While freeze is high at an edge, cur_value and new_flag are not updated by a completed average, and that average is discarded. The first average completed after freeze falls is published normally.
- R6: Any change of avg_cfg restarts the window and discards the partial sum. A sample presented on the edge where the change is seen is also discarded.
- R7: A synchronous active-high reset clears cur_value, new_flag, the partial window and the stored configuration (0, meaning one sample).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle strobe marking a valid sample |
| smp_data | input | 9 | Sample code |
| avg_cfg | input | 8 | Window length minus one |
| rd_pulse | input | 1 | Host read of the data word; clears new_flag |
| freeze | input | 1 | Hold level for the published reading |
| cur_value | output | 9 | Published mean |
| new_flag | output | 1 | Unread new reading indicator |

## Verification
Several properties are checked on every cycle. The divider's result must satisfy quotient times divisor plus remainder equal to the dividend, with the remainder below the divisor. The window counter must never pass the configured length. A freeze must hold both outputs, a publish must raise the flag, and a read without a publish must lower it. Only the bench's scenarios can show the end-to-end properties: the exact 19-edge latency, truncation on lengths that are not powers of two, the full 256-sample window, dropping of averages completed under freeze, and the discarding of a partial window when the configuration changes.

// File: rtl/avg_pkg.sv
package avg_pkg;
    localparam int SMP_W = 9;
    localparam int CFG_W = 8;
    localparam int ACC_W = SMP_W + CFG_W;
    localparam int CNT_W = CFG_W + 1;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/avg_accum.sv
module avg_accum #(
    parameter int SMP_W = avg_pkg::SMP_W,
    parameter int CFG_W = avg_pkg::CFG_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic [SMP_W-1:0]         smp_data,
    input  logic [CFG_W-1:0]         avg_cfg,
    output logic                     win_done,
    output logic [SMP_W+CFG_W-1:0]   win_sum,
    output logic [CFG_W:0]           win_n
);
    localparam int ACC_W = SMP_W + CFG_W;
    localparam int CNT_W = CFG_W + 1;

    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cnt;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] sum_next;

    assign sum_next = sum + ACC_W'(smp_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            cnt      <= '0;
            sum      <= '0;
            win_done <= 1'b0;
            win_sum  <= '0;
            win_n    <= '0;
        end else begin
            win_done <= 1'b0;
            if (avg_cfg != cfg_q) begin
                cfg_q <= avg_cfg;
                cnt   <= '0;
                sum   <= '0;
            end else if (smp_valid) begin
                if (cnt == cfg_q) begin
                    win_done <= 1'b1;
                    win_sum  <= sum_next;
                    win_n    <= CNT_W'(cfg_q) + CNT_W'(1);
                    cnt      <= '0;
                    sum      <= '0;
                end else begin
                    cnt <= cnt + CFG_W'(1);
                    sum <= sum_next;
                end
            end
        end
    end

    // R1: the position inside the window never passes the configured length
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= cfg_q);

    // R1: a closed window always reports a length of at least one
    a_r1_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        win_done |-> (win_n != '0));

    // R6: a configuration change leaves an empty window behind
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (avg_cfg != cfg_q) |=> (cnt == '0 && sum == '0 && !win_done));
endmodule

// File: rtl/avg_divider.sv
module avg_divider #(
    parameter int DVD_W = avg_pkg::ACC_W,
    parameter int DVS_W = avg_pkg::CNT_W,
    parameter int Q_W   = avg_pkg::SMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [Q_W-1:0]   quotient
);
    import avg_pkg::*;

    localparam int STEPS  = DVD_W;
    localparam int STEP_W = $clog2(STEPS + 1);
    localparam int PROD_W = DVD_W + DVS_W + 1;

    div_state_e       state;
    logic [STEP_W-1:0] step;
    logic [DVS_W-1:0] rem;
    logic [DVS_W-1:0] dvs;
    logic [DVD_W-1:0] dvd;
    logic [DVD_W-1:0] num;

    logic [DVS_W:0]   trial;
    logic             nxt_bit;
    logic [DVS_W-1:0] nxt_rem;

    always_comb begin
        trial   = {rem, dvd[DVD_W-1]};
        nxt_bit = (trial >= {1'b0, dvs});
        nxt_rem = nxt_bit ? DVS_W'(trial - {1'b0, dvs}) : trial[DVS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DV_IDLE;
            step     <= '0;
            rem      <= '0;
            dvs      <= '0;
            dvd      <= '0;
            num      <= '0;
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                DV_IDLE: begin
                    if (start) begin
                        dvd   <= dividend;
                        num   <= dividend;
                        dvs   <= divisor;
                        rem   <= '0;
                        step  <= '0;
                        state <= DV_RUN;
                    end
                end
                default: begin
                    rem <= nxt_rem;
                    dvd <= {dvd[DVD_W-2:0], nxt_bit};
                    if (step == STEP_W'(STEPS - 1)) begin
                        state    <= DV_IDLE;
                        done     <= 1'b1;
                        quotient <= {dvd[Q_W-2:0], nxt_bit};
                    end else begin
                        step <= step + STEP_W'(1);
                    end
                end
            endcase
        end
    end

    // R2: quotient and remainder reconstruct the dividend, remainder below divisor
    a_r2_exact_division: assert property (@(posedge clk) disable iff (rst)
        done |-> ((PROD_W'(quotient) * PROD_W'(dvs) + PROD_W'(rem) == PROD_W'(num))
                  && (rem < dvs)));

    // R3: a start request always launches the iteration
    a_r3_start_runs: assert property (@(posedge clk) disable iff (rst)
        (start && state == DV_IDLE) |=> (state == DV_RUN));

    // R3: a result is signalled for a single cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/avg_publish.sv
module avg_publish #(
    parameter int SMP_W = avg_pkg::SMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [SMP_W-1:0] res_value,
    input  logic             freeze,
    input  logic             rd_pulse,
    output logic [SMP_W-1:0] cur_value,
    output logic             new_flag
);
    logic take;

    assign take = res_valid && !freeze;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_value <= '0;
            new_flag  <= 1'b0;
        end else if (take) begin
            cur_value <= res_value;
            new_flag  <= 1'b1;
        end else if (rd_pulse) begin
            new_flag  <= 1'b0;
        end
    end

    // R5: a frozen edge leaves the published reading untouched
    a_r5_freeze_value: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(cur_value));

    // R5: a frozen edge never raises the flag
    a_r5_freeze_flag: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !$rose(new_flag));

    // R4: a publish sets the flag and carries the divider's result, even with a read
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !freeze) |=> (new_flag && cur_value == $past(res_value)));

    // R4: a read with no publish clears the flag
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_pulse && !(res_valid && !freeze)) |=> !new_flag);
endmodule

// File: rtl/sample_averager.sv
module sample_averager #(
    parameter int SMP_W = avg_pkg::SMP_W,
    parameter int CFG_W = avg_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [CFG_W-1:0] avg_cfg,
    input  logic             rd_pulse,
    input  logic             freeze,
    output logic [SMP_W-1:0] cur_value,
    output logic             new_flag
);
    localparam int ACC_W = SMP_W + CFG_W;
    localparam int CNT_W = CFG_W + 1;

    logic             win_done;
    logic [ACC_W-1:0] win_sum;
    logic [CNT_W-1:0] win_n;
    logic             div_done;
    logic [SMP_W-1:0] div_q;

    avg_accum #(.SMP_W(SMP_W), .CFG_W(CFG_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .avg_cfg   (avg_cfg),
        .win_done  (win_done),
        .win_sum   (win_sum),
        .win_n     (win_n)
    );

    avg_divider #(.DVD_W(ACC_W), .DVS_W(CNT_W), .Q_W(SMP_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (win_done),
        .dividend (win_sum),
        .divisor  (win_n),
        .done     (div_done),
        .quotient (div_q)
    );

    avg_publish #(.SMP_W(SMP_W)) u_pub (
        .clk       (clk),
        .rst       (rst),
        .res_valid (div_done),
        .res_value (div_q),
        .freeze    (freeze),
        .rd_pulse  (rd_pulse),
        .cur_value (cur_value),
        .new_flag  (new_flag)
    );
endmodule

// File: tb/test_sample_averager.sv
`timescale 1ns/1ps
module test_sample_averager;
    logic       clk = 1'b0;
    logic       rst;
    logic       smp_valid;
    logic [8:0] smp_data;
    logic [7:0] avg_cfg;
    logic       rd_pulse;
    logic       freeze;
    logic [8:0] cur_value;
    logic       new_flag;

    always #5 clk = ~clk;

    sample_averager i_sample_averager (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .avg_cfg(avg_cfg), .rd_pulse(rd_pulse), .freeze(freeze),
        .cur_value(cur_value), .new_flag(new_flag)
    );

    int total = 0;
    int bad   = 0;

    // reference model state
    int cyc = 0;
    int m_cfg = 0;
    int m_cnt = 0;
    int m_sum = 0;
    int exp_cur = 0;
    int exp_flag = 0;
    int due_q[$];
    int val_q[$];

    int cfg_drv = 0;
    bit frz_drv = 1'b0;

    localparam int LATENCY = 19;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input bit v, input int d, input bit rd);
        @(negedge clk);
        smp_valid = v;
        smp_data  = 9'(d);
        avg_cfg   = 8'(cfg_drv);
        rd_pulse  = rd;
        freeze    = frz_drv;
        @(posedge clk);
        cyc++;
        // publish stage
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            if (!frz_drv) begin
                exp_cur  = val_q[0];
                exp_flag = 1;
            end else if (rd) begin
                exp_flag = 0;
            end
            void'(due_q.pop_front());
            void'(val_q.pop_front());
        end else if (rd) begin
            exp_flag = 0;
        end
        // window stage
        if (cfg_drv != m_cfg) begin
            m_cfg = cfg_drv;
            m_cnt = 0;
            m_sum = 0;
        end else if (v) begin
            m_sum += d;
            m_cnt++;
            if (m_cnt == m_cfg + 1) begin
                due_q.push_back(cyc + LATENCY);
                val_q.push_back(m_sum / (m_cfg + 1));
                m_cnt = 0;
                m_sum = 0;
            end
        end
        #1;
        chk("R3 cur_value", int'(cur_value), exp_cur);
        chk("R4 new_flag", int'(new_flag), exp_flag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0);
    endtask

    task automatic feed(input int d);
        step(1'b1, d, 1'b0);
        idle(21);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; smp_data = '0; avg_cfg = '0;
        rd_pulse = 1'b0; freeze = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset cur_value", int'(cur_value), 0);
        chk("R7 reset new_flag", int'(new_flag), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: code 0 averages a single sample
        feed(5);
        chk("R1 single sample", int'(cur_value), 5);
        feed(511);
        chk("R1 full scale single", int'(cur_value), 511);
        feed(0);
        step(1'b0, 0, 1'b1);
        chk("R4 read clears", int'(new_flag), 0);

        // R2: four samples, truncated mean
        cfg_drv = 3; idle(1);
        feed(10); feed(20); feed(30); feed(41);
        chk("R2 mean of four", int'(cur_value), 25);

        // R2: length three, not a power of two
        cfg_drv = 2; idle(1);
        feed(1); feed(1); feed(2);
        chk("R2 truncation N=3", int'(cur_value), 1);

        // R4: publish and read on the same edge
        feed(3); feed(3);
        step(1'b1, 3, 1'b0);
        idle(LATENCY - 1);
        step(1'b0, 0, 1'b1);
        chk("R4 set wins over read", int'(new_flag), 1);
        chk("R3 latency value", int'(cur_value), 3);
        step(1'b0, 0, 1'b1);
        chk("R4 later read clears", int'(new_flag), 0);

        // R5: freeze drops averages
        cfg_drv = 0; idle(1);
        feed(100);
        step(1'b0, 0, 1'b1);
        frz_drv = 1'b1;
        feed(200);
        chk("R5 frozen value held", int'(cur_value), 100);
        chk("R5 frozen flag held", int'(new_flag), 0);
        frz_drv = 1'b0;
        feed(300 - 0);
        chk("R5 publish after thaw", int'(cur_value), 300);

        // R6: configuration change mid-window discards the partial sum
        cfg_drv = 3; idle(1);
        feed(50); feed(60);
        cfg_drv = 1;
        feed(400);
        feed(7); feed(9);
        chk("R6 restarted window", int'(cur_value), 8);

        // R1: 256-sample window
        step(1'b0, 0, 1'b1);
        cfg_drv = 255; idle(1);
        for (int i = 0; i < 255; i++) feed(511);
        chk("R1 no early publish", int'(new_flag), 0);
        chk("R1 value kept early", int'(cur_value), 8);
        feed(511);
        chk("R1 full window", int'(cur_value), 511);
        for (int i = 0; i < 256; i++) feed((i % 2 == 0) ? 0 : 511);
        chk("R2 alternating 256", int'(cur_value), 255);

        summary();
    end
endmodule